// File: doc/BRIEF.md
# Two-Thread Interleaved Microsequencer

This block is a microprogrammed engine that runs two independent instruction streams out of one read-only microcode store. Thread 0 carries the host-side program and thread 1 the drive-side program. Each thread owns a 12-bit microprogram counter, a 16-entry register bank, a return register and its own zero, carry and negative flags. A single 16-bit ALU serves both threads.

The threads time-share the engine in fixed alternation. In every cycle one thread presents its counter on the ROM address port while the other executes the word it fetched in the cycle before. The roles swap on every clock. Because a thread only issues every second cycle, its next fetch always sees its own updated counter, and no hazard logic is needed. The microcode image and the bus protocols around the engine sit outside the block; the ROM read port is combinational from `rom_addr` to `rom_data`.

Top module: `dual_useq`

## Requirements
- R1: While reset is held and in the first cycle after release, `exec_valid` is 0 and `rom_addr` is 0. Thread 0 restarts at address 0x000 and thread 1 at 0x800. Registers, flags and return registers clear, with thread 1's return register set to 0x800.
- R2: From the second cycle after reset on, `exec_valid` is 1 in every cycle. `exec_tid` is 0 in the first executing cycle and toggles on every clock after that.
- R3: In an executing cycle, `rom_addr` equals the counter of the thread that is not executing. The word returned there is executed by that thread in the next cycle. `exec_pc` gives the address that word came from.
- R4: A microinstruction is 31 bits: opcode [30:27], destination [26:23], source A [22:19], source B [18:15], condition [14:12] and target or immediate [11:0].
- R5: The opcodes work as follows. 1 writes A+B and 2 writes A-B. 3, 4 and 5 write A AND B, A OR B and A XOR B. 6 copies A. 7 writes the zero-extended 12-bit immediate. 8 writes A shifted left by one and 9 writes A shifted right by one, shifting in zero. Opcodes 1 to 9 write the destination register, shown on `wb_en`, `wb_dst` and `wb_data` during the executing cycle. Opcodes 0 and 12 to 15 write nothing.
- R6: Opcodes 1 to 5, 8 and 9 update the executing thread's flags, and opcodes 6 and 7 leave them alone. Z is set when the result is 0 and N is bit 15 of the result. C is the carry out for ADD, the borrow (A < B unsigned) for SUB, A[15] for a left shift, A[0] for a right shift, and 0 for the logic ops.
- R7: The condition codes are 0 never, 1 always, 2 Z, 3 not Z, 4 C, 5 N, 6 the thread's `ext_cond` bit and 7 its inverse. They test the thread's flags as they stood before the instruction. When the condition holds the counter loads the target, and otherwise it increments modulo 4096.
- R8: Opcode 10 (call) saves the counter plus one in the thread's single return register and jumps to the target, whatever the condition field holds. Opcode 11 (return) loads the counter from that register.
- R9: One thread's execution never changes the other thread's counter, registers, flags or return register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_addr | output | 12 | Microcode address of the fetching thread |
| rom_data | input | 31 | Microinstruction read combinationally at rom_addr |
| ext_cond | input | 2 | External branch condition, bit n belongs to thread n |
| exec_valid | output | 1 | A microinstruction executes this cycle |
| exec_tid | output | 1 | Thread that executes this cycle |
| exec_pc | output | 12 | Address of the executing microinstruction |
| wb_en | output | 1 | Register write this cycle |
| wb_dst | output | 4 | Destination register index in the executing thread |
| wb_data | output | 16 | Value being written |

## Verification
A word placed on `rom_data` in cycle k is executed in cycle k+1. Its write-back shows combinationally on the wb outputs in that same cycle and commits at the closing edge. Flag and counter effects become visible two cycles later, when the same thread next executes or fetches. The bench samples every output on the falling edge of each cycle, after the external condition has been changed just past the rising edge. It steps its own instruction-level model of both threads once per executing cycle, so every expected value lands in the cycle where the design produces it.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam logic [3:0] OP_NOP = 4'd0;
  localparam logic [3:0] OP_ADD = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_AND = 4'd3;
  localparam logic [3:0] OP_OR  = 4'd4;
  localparam logic [3:0] OP_XOR = 4'd5;
  localparam logic [3:0] OP_MOV = 4'd6;
  localparam logic [3:0] OP_LDI = 4'd7;
  localparam logic [3:0] OP_SHL = 4'd8;
  localparam logic [3:0] OP_SHR = 4'd9;
  localparam logic [3:0] OP_CALL = 4'd10;
  localparam logic [3:0] OP_RET  = 4'd11;

  localparam logic [2:0] CC_NEVER = 3'd0;
  localparam logic [2:0] CC_ALWAYS = 3'd1;
  localparam logic [2:0] CC_Z    = 3'd2;
  localparam logic [2:0] CC_NZ   = 3'd3;
  localparam logic [2:0] CC_C    = 3'd4;
  localparam logic [2:0] CC_N    = 3'd5;
  localparam logic [2:0] CC_EXT  = 3'd6;
  localparam logic [2:0] CC_NEXT = 3'd7;

  typedef struct packed {
    logic z;
    logic c;
    logic n;
  } flags_t;

  function automatic logic cond_met(input logic [2:0] cc, input flags_t f, input logic x);
    case (cc)
      CC_ALWAYS: cond_met = 1'b1;
      CC_Z:      cond_met = f.z;
      CC_NZ:     cond_met = !f.z;
      CC_C:      cond_met = f.c;
      CC_N:      cond_met = f.n;
      CC_EXT:    cond_met = x;
      CC_NEXT:   cond_met = !x;
      default:   cond_met = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/useq_alu.sv
module useq_alu
  import useq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] imm,
  output logic [DW-1:0] res,
  output flags_t        flg,
  output logic          wr,
  output logic          fupd
);
  // returns {carry, result}
  function automatic logic [DW:0] alu_calc(input logic [3:0] o, input logic [DW-1:0] x,
                                           input logic [DW-1:0] y, input logic [DW-1:0] k);
    case (o)
      OP_ADD:  alu_calc = {1'b0, x} + {1'b0, y};
      OP_SUB:  alu_calc = {(x < y), x - y};
      OP_AND:  alu_calc = {1'b0, x & y};
      OP_OR:   alu_calc = {1'b0, x | y};
      OP_XOR:  alu_calc = {1'b0, x ^ y};
      OP_MOV:  alu_calc = {1'b0, x};
      OP_LDI:  alu_calc = {1'b0, k};
      OP_SHL:  alu_calc = {x[DW-1], x[DW-2:0], 1'b0};
      OP_SHR:  alu_calc = {x[0], 1'b0, x[DW-1:1]};
      default: alu_calc = '0;
    endcase
  endfunction

  function automatic logic writes_reg(input logic [3:0] o);
    writes_reg = (o >= OP_ADD) && (o <= OP_SHR);
  endfunction

  function automatic logic writes_flags(input logic [3:0] o);
    writes_flags = ((o >= OP_ADD) && (o <= OP_XOR)) || (o == OP_SHL) || (o == OP_SHR);
  endfunction

  logic [DW:0] full;
  always_comb begin
    full  = alu_calc(op, a, b, imm);
    res   = full[DW-1:0];
    flg.c = full[DW];
    flg.z = (full[DW-1:0] == '0);
    flg.n = full[DW-1];
    wr    = writes_reg(op);
    fupd  = writes_flags(op);
  end
endmodule

// File: rtl/useq_ctx.sv
module useq_ctx
  import useq_pkg::*;
#(
  parameter int PC_W = 12,
  parameter int DW   = 16,
  parameter int RA_W = 4,
  parameter logic [PC_W-1:0] BASE = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exec_en,
  input  logic [3:0]      op,
  input  logic [RA_W-1:0] dst,
  input  logic [RA_W-1:0] sa,
  input  logic [RA_W-1:0] sb,
  input  logic [2:0]      cc,
  input  logic [PC_W-1:0] tgt,
  input  logic [DW-1:0]   res,
  input  flags_t          alu_flg,
  input  logic            alu_wr,
  input  logic            alu_fupd,
  input  logic            xcond,
  output logic [PC_W-1:0] pc_o,
  output logic [DW-1:0]   rd_a,
  output logic [DW-1:0]   rd_b
);
  localparam int NREG = 1 << RA_W;

  logic [PC_W-1:0] pc_q, ret_q, pc_nxt, ret_nxt, pc_inc;
  flags_t          flg_q;
  logic [DW-1:0]   rf [NREG];
  logic            take;

  assign pc_inc = pc_q + 1'b1;
  assign take   = cond_met(cc, flg_q, xcond);

  always_comb begin
    pc_nxt  = take ? tgt : pc_inc;
    ret_nxt = ret_q;
    if (op == OP_CALL) begin
      pc_nxt  = tgt;
      ret_nxt = pc_inc;
    end else if (op == OP_RET) begin
      pc_nxt = ret_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= BASE;
      ret_q <= BASE;
      flg_q <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (exec_en) begin
      pc_q  <= pc_nxt;
      ret_q <= ret_nxt;
      if (alu_fupd) flg_q <= alu_flg;
      if (alu_wr) rf[dst] <= res;
    end
  end

  assign pc_o = pc_q;
  assign rd_a = rf[sa];
  assign rd_b = rf[sb];

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> ($stable(pc_q) && $stable(flg_q) && $stable(ret_q)));
  // R8
  ret_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op == OP_RET) |=> (pc_q == $past(ret_q)));
  // R8
  call_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op == OP_CALL) |=> (ret_q == PC_W'($past(pc_q) + 1'b1) && pc_q == $past(tgt)));
  // R7
  never_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op != OP_CALL && op != OP_RET && cc == CC_NEVER)
      |=> (pc_q == PC_W'($past(pc_q) + 1'b1)));
endmodule

// File: rtl/dual_useq.sv
module dual_useq
  import useq_pkg::*;
#(
  parameter int PC_W = 12,
  parameter int DW   = 16,
  parameter int RA_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic [PC_W-1:0]               rom_addr,
  input  logic [4+3*RA_W+3+PC_W-1:0]    rom_data,
  input  logic [1:0]                    ext_cond,
  output logic                          exec_valid,
  output logic                          exec_tid,
  output logic [PC_W-1:0]               exec_pc,
  output logic                          wb_en,
  output logic [RA_W-1:0]               wb_dst,
  output logic [DW-1:0]                 wb_data
);
  localparam int IW = 4 + 3*RA_W + 3 + PC_W;
  localparam int NTH = 2;
  localparam logic [PC_W-1:0] T1_BASE = PC_W'(1) << (PC_W-1);

  logic          fetch_tid, ir_vld;
  logic [IW-1:0] ir;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_tid <= 1'b0;
      ir_vld    <= 1'b0;
      ir        <= '0;
    end else begin
      fetch_tid <= ~fetch_tid;
      ir_vld    <= 1'b1;
      ir        <= rom_data;
    end
  end

  logic            ex_tid;
  logic [3:0]      f_op;
  logic [RA_W-1:0] f_dst, f_sa, f_sb;
  logic [2:0]      f_cc;
  logic [PC_W-1:0] f_tgt;

  assign ex_tid = ~fetch_tid;
  assign {f_op, f_dst, f_sa, f_sb, f_cc, f_tgt} = ir;

  logic [PC_W-1:0] pc_v [NTH];
  logic [DW-1:0]   ra_v [NTH];
  logic [DW-1:0]   rb_v [NTH];
  logic [DW-1:0]   alu_res;
  flags_t          alu_flg;
  logic            alu_wr, alu_fupd;

  useq_alu #(.DW(DW)) u_alu (
    .op(f_op), .a(ra_v[ex_tid]), .b(rb_v[ex_tid]), .imm(DW'(f_tgt)),
    .res(alu_res), .flg(alu_flg), .wr(alu_wr), .fupd(alu_fupd)
  );

  for (genvar g = 0; g < NTH; g++) begin : g_ctx
    useq_ctx #(
      .PC_W(PC_W), .DW(DW), .RA_W(RA_W),
      .BASE((g == 0) ? '0 : T1_BASE)
    ) u_ctx (
      .clk(clk), .rst_n(rst_n),
      .exec_en(ir_vld && (ex_tid == 1'(g))),
      .op(f_op), .dst(f_dst), .sa(f_sa), .sb(f_sb), .cc(f_cc), .tgt(f_tgt),
      .res(alu_res), .alu_flg(alu_flg), .alu_wr(alu_wr), .alu_fupd(alu_fupd),
      .xcond(ext_cond[g]),
      .pc_o(pc_v[g]), .rd_a(ra_v[g]), .rd_b(rb_v[g])
    );
  end

  assign rom_addr   = pc_v[fetch_tid];
  assign exec_valid = ir_vld;
  assign exec_tid   = ex_tid;
  assign exec_pc    = pc_v[ex_tid];
  assign wb_en      = ir_vld && alu_wr;
  assign wb_dst     = f_dst;
  assign wb_data    = alu_res;

  // R2
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |=> (exec_valid && exec_tid != $past(exec_tid)));
  // R2
  first_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_valid) |-> (exec_tid == 1'b0));
  // R3
  fetch_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> (rom_addr == pc_v[~exec_tid]));
endmodule

// File: tb/dual_useq_tb.sv
module dual_useq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] rom_addr;
  logic [30:0] rom_data;
  logic [1:0]  ext_cond;
  logic        exec_valid, exec_tid, wb_en;
  logic [11:0] exec_pc;
  logic [3:0]  wb_dst;
  logic [15:0] wb_data;

  always #4 clk = ~clk;

  dual_useq u_dut (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
    .ext_cond(ext_cond), .exec_valid(exec_valid), .exec_tid(exec_tid),
    .exec_pc(exec_pc), .wb_en(wb_en), .wb_dst(wb_dst), .wb_data(wb_data)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R4: word layout {op, dst, srcA, srcB, cond, target}
  function automatic logic [30:0] enc(input int op, input int d, input int a, input int b,
                                      input int cc, input int t);
    enc = {4'(op), 4'(d), 4'(a), 4'(b), 3'(cc), 12'(t)};
  endfunction

  logic [30:0] p0 [32];
  logic [30:0] p1 [32];

  initial begin
    for (int i = 0; i < 32; i++) begin p0[i] = '0; p1[i] = '0; end
    p0[0]  = enc(7, 1, 0, 0, 0, 12'h0FF);
    p0[1]  = enc(7, 2, 0, 0, 0, 12'h123);
    p0[2]  = enc(7, 4, 0, 0, 0, 1);
    p0[3]  = enc(1, 3, 1, 2, 0, 0);
    p0[4]  = enc(2, 5, 1, 2, 0, 0);
    p0[5]  = enc(3, 6, 1, 2, 0, 0);
    p0[6]  = enc(4, 7, 1, 2, 0, 0);
    p0[7]  = enc(5, 8, 1, 2, 0, 0);
    p0[8]  = enc(8, 1, 1, 0, 0, 0);
    p0[9]  = enc(9, 9, 2, 0, 0, 0);
    p0[10] = enc(6, 10, 3, 0, 0, 0);
    p0[11] = enc(10, 0, 0, 0, 3, 20);
    p0[12] = enc(1, 2, 2, 1, 2, 15);
    p0[13] = enc(0, 0, 0, 0, 4, 16);
    p0[14] = enc(0, 0, 0, 0, 5, 3);
    p0[15] = enc(5, 11, 11, 11, 6, 3);
    p0[16] = enc(2, 12, 4, 4, 3, 3);
    p0[17] = enc(15, 1, 1, 1, 1, 3);
    p0[20] = enc(1, 13, 13, 4, 0, 0);
    p0[21] = enc(11, 0, 0, 0, 0, 5);
    p1[0]  = enc(7, 1, 0, 0, 0, 12'h7FF);
    p1[1]  = enc(7, 2, 0, 0, 0, 12'h801);
    p1[2]  = enc(1, 1, 1, 2, 0, 0);
    p1[3]  = enc(8, 3, 1, 0, 0, 0);
    p1[4]  = enc(2, 4, 2, 1, 4, 12'h807);
    p1[5]  = enc(4, 5, 5, 3, 5, 12'h808);
    p1[6]  = enc(10, 0, 0, 0, 0, 12'h810);
    p1[7]  = enc(5, 6, 1, 4, 2, 12'h802);
    p1[8]  = enc(3, 7, 1, 3, 3, 12'h802);
    p1[9]  = enc(12, 8, 0, 0, 7, 12'h802);
    p1[10] = enc(6, 0, 7, 0, 1, 12'h802);
    p1[16] = enc(9, 8, 1, 0, 0, 0);
    p1[17] = enc(11, 0, 0, 0, 6, 12'h803);
  end

  always_comb begin
    if (rom_addr < 12'd32) rom_data = p0[rom_addr[4:0]];
    else if (rom_addr >= 12'h800 && rom_addr < 12'h820) rom_data = p1[rom_addr[4:0]];
    else rom_data = '0;
  end

  // instruction-level model of both threads
  logic [11:0] m_pc [2];
  logic [11:0] m_ret [2];
  logic [15:0] m_r [2][16];
  bit m_z [2], m_c [2], m_n [2];
  bit m_tid;

  task automatic model_reset();
    m_pc[0] = 12'h000; m_pc[1] = 12'h800;
    m_ret[0] = 12'h000; m_ret[1] = 12'h800;
    for (int t = 0; t < 2; t++) begin
      m_z[t] = 0; m_c[t] = 0; m_n[t] = 0;
      for (int r = 0; r < 16; r++) m_r[t][r] = 16'h0;
    end
    m_tid = 0;
  endtask

  task automatic step_and_check();
    logic [30:0] w;
    int op, d, a, b, cc, t, va, vb, sum;
    bit wr, fu, cy, go;
    logic [15:0] rv;
    w = (m_pc[m_tid] < 12'd32) ? p0[m_pc[m_tid][4:0]] :
        (m_pc[m_tid] >= 12'h800 && m_pc[m_tid] < 12'h820) ? p1[m_pc[m_tid][4:0]] : 31'h0;
    op = int'(w[30:27]); d = int'(w[26:23]); a = int'(w[22:19]); b = int'(w[18:15]);
    cc = int'(w[14:12]); t = int'(w[11:0]);
    va = int'(m_r[m_tid][a]); vb = int'(m_r[m_tid][b]);
    wr = (op >= 1 && op <= 9);
    fu = (op >= 1 && op <= 5) || op == 8 || op == 9;
    cy = 0; sum = 0;
    case (op)
      1: begin sum = va + vb; cy = (sum > 65535); end
      2: begin sum = va - vb; cy = (va < vb); end
      3: sum = va & vb;
      4: sum = va | vb;
      5: sum = va ^ vb;
      6: sum = va;
      7: sum = t;
      8: begin sum = va * 2; cy = (va >= 32768); end
      9: begin sum = va / 2; cy = (va % 2 == 1); end
      default: sum = 0;
    endcase
    rv = 16'(sum);
    check(exec_tid == m_tid, "R2 thread", exec_tid, m_tid);
    check(exec_pc == m_pc[m_tid], "R3 exec address", exec_pc, m_pc[m_tid]);
    check(rom_addr == m_pc[!m_tid], "R3 fetch address", rom_addr, m_pc[!m_tid]);
    check(wb_en == wr, "R5 write enable", wb_en, wr);
    if (wr) begin
      check(wb_dst == 4'(d), "R4 destination field", wb_dst, d);
      check(wb_data == rv, "R5 R6 result", wb_data, rv);
    end
    case (cc)
      1: go = 1;
      2: go = m_z[m_tid];
      3: go = !m_z[m_tid];
      4: go = m_c[m_tid];
      5: go = m_n[m_tid];
      6: go = ext_cond[m_tid];
      7: go = !ext_cond[m_tid];
      default: go = 0;
    endcase
    if (op == 10) begin
      m_ret[m_tid] = 12'(m_pc[m_tid] + 1);
      m_pc[m_tid] = 12'(t);
    end else if (op == 11) m_pc[m_tid] = m_ret[m_tid];
    else m_pc[m_tid] = go ? 12'(t) : 12'(m_pc[m_tid] + 1);
    if (wr) m_r[m_tid][d] = rv;
    if (fu) begin
      m_z[m_tid] = (rv == 0); m_n[m_tid] = rv[15]; m_c[m_tid] = cy;
    end
    m_tid = !m_tid;
  endtask

  logic [7:0] lfsr = 8'h5B;

  task automatic run_phase(input int ncyc);
    rst_n = 1'b0;
    ext_cond = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state while held
    check(exec_valid == 1'b0, "R1 valid in reset", exec_valid, 0);
    check(rom_addr == 12'h000, "R1 address in reset", rom_addr, 0);
    check(wb_en == 1'b0, "R1 no write in reset", wb_en, 0);
    rst_n = 1'b1;
    model_reset();
    #1;
    // R1 first cycle after release: fetch only
    check(exec_valid == 1'b0, "R1 first cycle idle", exec_valid, 0);
    check(rom_addr == 12'h000, "R1 first fetch", rom_addr, 0);
    for (int k = 0; k < ncyc; k++) begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ext_cond = lfsr[1:0];
      @(negedge clk);
      check(exec_valid == 1'b1, "R2 valid every cycle", exec_valid, 1);
      if (k == 0) check(exec_tid == 1'b0, "R2 thread 0 first", exec_tid, 0);
      if (k == 1) check(exec_pc == 12'h800, "R1 thread 1 start", exec_pc, 12'h800);
      step_and_check();   // also covers R7 R8 R9 via each thread's next address
    end
  endtask

  initial begin
    run_phase(500);
    run_phase(300);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule